// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block sits between a clock generator's internal clock phases and its output pins. It stops and restarts those clocks cleanly when an active-low, asynchronous power-down request changes. The request is synchronized to the CPU reference clock. It is accepted only after it has been seen low on consecutive qualified samples. Every output then closes its own gate during a low phase of its source, so no high pulse is ever shortened. Once every output is quiet, the block raises an indication that the oscillator and VCO may stop.

When the request is released, the stop indication drops. A parameterized wait then covers the oscillator's restart time. After that wait, each output reopens, again only during a low phase of its source, so its first high pulse is full width. The same low-phase-aligned gate also applies a per-output enable bit, so a change to an enable bit never produces a runt pulse. A global tristate bit controls a drive-enable vector that releases all pins to high impedance without disturbing the clock sequencing.

Top module: `clk_stop_seq`

## Requirements
- R1: While reset is asserted, every `clk_out` bit is 0, every `clk_oe` bit is 0 and `osc_stop` is 0.
- R2: `pd_n` passes through a 2-stage synchronizer and is accepted only when the synchronized value is low on 2 consecutive rising edges of `clk`. A low pulse that is captured on only one edge has no effect: `osc_stop` stays 0 and the outputs keep switching.
- R3: Every high pulse on `clk_out[i]` lasts exactly as many cycles as the high phase of `src_clk[i]`. No output ever produces a shortened pulse, whether it is stopping or starting.
- R4: After acceptance, each output finishes its current high phase and is then held low. `osc_stop` rises only after all outputs are low. While `osc_stop` is 1, every `clk_out` bit stays 0 and does not switch. From `pd_n` falling (driven between edges), `osc_stop` rises no sooner than 7 edges and no later than 7 edges plus the longest source high phase.
- R5: When `pd_n` returns high, `osc_stop` falls on the 4th rising edge of `clk` after the change, and not before.
- R6: After `osc_stop` falls, no output rises for at least `RESTART_CYC`+2 edges. Every enabled output resumes within `RESTART_CYC`+2+2×(its source half period) edges. `RESTART_CYC` must not exceed `MAX_LATENCY_CYC`, which is checked at elaboration.
- R7: Writing 0 to bit i of `out_en` stops `clk_out[i]` after its current high phase, and it then stays low. The other outputs are not affected.
- R8: Writing 1 back to bit i of `out_en` lets `clk_out[i]` switch again, starting at a low phase of `src_clk[i]`.
- R9: `clk_oe` is all 0 one edge after `tristate` is 1, and all 1 one edge after `tristate` is 0. `tristate` has no effect on the switching of `clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU reference clock; all state is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| src_clk | input | N_OUT | Internal clock phases to be gated, synchronous to `clk` |
| out_en | input | N_OUT | Per-output enable (1 = run) |
| tristate | input | 1 | 1 releases all outputs to high impedance |
| clk_out | output | N_OUT | Gated clocks, one edge behind `src_clk` |
| clk_oe | output | N_OUT | Per-output drive-enable |
| osc_stop | output | 1 | Oscillator and VCO stop indication |

## Verification
The output lags its source by one edge, so the pulse-width monitor measures every high pulse on each output and compares it with the source's half period. Request acceptance is due 5 edges after `pd_n` falls. The stop indication rises 2 or more edges later, once the slowest source has reached a low phase, so that check uses a window rather than a single cycle. Release is cycle exact: the stop indication must still be high 3 edges after `pd_n` rises and low after the 4th. The first rising edge of each output after the restart wait falls into a window of `RESTART_CYC`+2 edges plus up to two source half periods. The drive-enable is checked on the first falling edge of `clk` after `tristate` changes. Expected stop-indication transitions go into a queue, and a monitor matches them against the transitions it sees.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_STOP = 2'd1,
      ST_DOWN = 2'd2,
      ST_WAKE = 2'd3
   } seq_state_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/clkstop_pd_qual.sv
module clkstop_pd_qual #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned QUAL_COUNT  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_n_async,
   output logic pd_req
);
   localparam int unsigned CW = clkstop_pkg::cnt_width(QUAL_COUNT);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (QUAL_COUNT < 1) begin : g_bad_qual
      $error("QUAL_COUNT must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          low_cnt;
   logic                   sync_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b1;
      else        sync_q[0] <= pd_n_async;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b1;
         else        sync_q[s] <= sync_q[s-1];
      end
   end

   assign sync_low = ~sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      low_cnt <= '0;
      else if (!sync_low)              low_cnt <= '0;
      else if (low_cnt != CW'(QUAL_COUNT)) low_cnt <= low_cnt + 1'b1;
   end

   assign pd_req = (low_cnt == CW'(QUAL_COUNT));

   // R2: acceptance needs the synchronized request low on consecutive edges
   if (QUAL_COUNT >= 2) begin : g_chk2
      p_two_samples_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pd_req) |-> ($past(sync_low) && $past(sync_low, 2)));
   end
   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_req) |-> !$past(sync_low));
endmodule

// File: rtl/clkstop_gate_cell.sv
module clkstop_gate_cell #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic want_i,
   output logic gate_o,
   output logic clk_o
);
   logic gate_q;

   // the gate may only move while the source is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      gate_q <= 1'b0;
      else if (!src_i) gate_q <= want_i;
   end

   if (REG_OUT) begin : g_reg
      logic out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_q <= 1'b0;
         else        out_q <= src_i & gate_q;
      end
      assign clk_o = out_q;
   end else begin : g_comb
      assign clk_o = src_i & gate_q;
   end

   assign gate_o = gate_q;

   p_gate_moves_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_q != $past(gate_q)) |-> !$past(src_i));
   p_close_on_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!want_i && !src_i) |=> !gate_q);
   p_open_on_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (want_i && !src_i) |=> gate_q);
endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
   import clkstop_pkg::*;
#(
   parameter int unsigned RESTART_CYC     = 200000,
   parameter int unsigned MAX_LATENCY_CYC = 300000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_req,
   input  logic all_closed,
   output logic run,
   output logic osc_stop
);
   localparam int unsigned WW = cnt_width(RESTART_CYC);

   if (RESTART_CYC < 1) begin : g_bad_wait
      $error("RESTART_CYC must be at least 1");
   end
   if (RESTART_CYC > MAX_LATENCY_CYC) begin : g_bad_lat
      $error("RESTART_CYC exceeds the power-up latency bound");
   end

   seq_state_t state_q, state_d;
   logic [WW-1:0] wait_q;
   logic          wait_done;

   assign wait_done = (wait_q == WW'(RESTART_CYC - 1));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:  if (pd_req)     state_d = ST_STOP;
         ST_STOP: if (all_closed) state_d = ST_DOWN;
         ST_DOWN: if (!pd_req)    state_d = ST_WAKE;
         ST_WAKE: begin
            if (pd_req)         state_d = ST_DOWN;
            else if (wait_done) state_d = ST_RUN;
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         wait_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q != ST_WAKE) wait_q <= '0;
         else if (!wait_done)    wait_q <= wait_q + 1'b1;
      end
   end

   assign run      = (state_q == ST_RUN);
   assign osc_stop = (state_q == ST_DOWN);

   p_run_after_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !$past(run)) |-> ($past(state_q) == ST_WAKE && $past(wait_done)));
   p_down_after_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_stop && $past(state_q) == ST_STOP) |-> $past(all_closed));
endmodule

// File: rtl/clk_stop_seq.sv
module clk_stop_seq #(
   parameter int unsigned N_OUT           = 7,
   parameter int unsigned SYNC_STAGES     = 2,
   parameter int unsigned QUAL_COUNT      = 2,
   parameter int unsigned RESTART_CYC     = 200000,
   parameter int unsigned MAX_LATENCY_CYC = 300000,
   parameter bit          REG_OUT         = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_n,
   input  logic [N_OUT-1:0] src_clk,
   input  logic [N_OUT-1:0] out_en,
   input  logic             tristate,
   output logic [N_OUT-1:0] clk_out,
   output logic [N_OUT-1:0] clk_oe,
   output logic             osc_stop
);
   if (N_OUT < 1 || N_OUT > 64) begin : g_bad_n
      $error("N_OUT out of range");
   end

   logic             pd_req;
   logic             run;
   logic [N_OUT-1:0] gate_st;
   logic [N_OUT-1:0] want;
   logic [N_OUT-1:0] oe_q;

   clkstop_pd_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_COUNT(QUAL_COUNT)) u_qual (
      .clk(clk), .rst_n(rst_n), .pd_n_async(pd_n), .pd_req(pd_req));

   clkstop_fsm #(.RESTART_CYC(RESTART_CYC), .MAX_LATENCY_CYC(MAX_LATENCY_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .all_closed(~|gate_st),
      .run(run), .osc_stop(osc_stop));

   assign want = out_en & {N_OUT{run}};

   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      clkstop_gate_cell #(.REG_OUT(REG_OUT)) u_cell (
         .clk(clk), .rst_n(rst_n), .src_i(src_clk[i]), .want_i(want[i]),
         .gate_o(gate_st[i]), .clk_o(clk_out[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= '0;
      else        oe_q <= {N_OUT{~tristate}};
   end
   assign clk_oe = oe_q;

   p_quiet_when_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      osc_stop |-> (clk_out == '0));
   p_no_rise_in_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_stop && $past(osc_stop)) |-> $stable(clk_out));
   p_oe_uniform_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_oe == '0) || (clk_oe == '1));
endmodule

// File: tb/tb_clk_stop_seq.sv
module tb_clk_stop_seq;
   localparam int N   = 7;
   localparam int RST = 20;
   localparam int MAXH = N;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pd_n = 1'b1;
   logic [N-1:0] src = '0;
   logic [N-1:0] en = '1;
   logic tristate = 1'b0;
   logic [N-1:0] clk_out, clk_oe;
   logic osc_stop;

   int checks = 0, errors = 0;
   int rise_cnt [N];
   int hi_len [N];
   bit prev_out [N];
   bit prev_osc = 1'b0;
   bit exp_osc_q[$];

   always #2.5 clk = ~clk;

   clk_stop_seq #(.N_OUT(N), .RESTART_CYC(RST), .MAX_LATENCY_CYC(RST)) dut (
      .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .src_clk(src), .out_en(en),
      .tristate(tristate), .clk_out(clk_out), .clk_oe(clk_oe), .osc_stop(osc_stop));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // source phases: output i has a half period of i+1 cycles
   initial begin
      int cnt [N];
      for (int i = 0; i < N; i++) cnt[i] = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            for (int i = 0; i < N; i++) begin
               cnt[i]++;
               if (cnt[i] == i + 1) begin
                  cnt[i] = 0;
                  src[i] = ~src[i];
               end
            end
         end
      end
   end

   // monitor: pulse widths (R3), rises, stop indication scoreboard (R4/R5)
   initial begin
      for (int i = 0; i < N; i++) begin
         rise_cnt[i] = 0; hi_len[i] = 0; prev_out[i] = 1'b0;
      end
      forever begin
         @(negedge clk);
         if (rst_n) begin
            for (int i = 0; i < N; i++) begin
               if (clk_out[i]) begin
                  hi_len[i]++;
                  if (!prev_out[i]) rise_cnt[i]++;
               end else if (prev_out[i]) begin
                  chk(hi_len[i] == i + 1, "R3", $sformatf("pulse width out%0d", i),
                      hi_len[i], i + 1);
                  hi_len[i] = 0;
               end
               prev_out[i] = clk_out[i];
            end
            if (osc_stop != prev_osc) begin
               if (exp_osc_q.size() == 0)
                  chk(1'b0, "R4", "unexpected osc_stop change", osc_stop, prev_osc);
               else begin
                  bit e;
                  e = exp_osc_q.pop_front();
                  chk(osc_stop == e, "R4", "osc_stop transition", osc_stop, e);
               end
               prev_osc = osc_stop;
            end
            if (osc_stop)
               chk(clk_out == '0, "R4", "outputs low while stopped", int'(clk_out), 0);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      finish_sim();
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   initial begin
      int base [N];
      int k;
      int first [N];
      step(3);
      // R1: reset state
      chk(clk_out == '0, "R1", "clk_out in reset", int'(clk_out), 0);
      chk(clk_oe == '0, "R1", "clk_oe in reset", int'(clk_oe), 0);
      chk(osc_stop == 1'b0, "R1", "osc_stop in reset", osc_stop, 0);
      @(negedge clk); rst_n = 1'b1;
      step(40);
      chk(clk_oe == '1, "R9", "oe after reset, tristate 0", int'(clk_oe), 127);

      // R2: single-edge low pulse is ignored
      for (int i = 0; i < N; i++) base[i] = rise_cnt[i];
      @(negedge clk); pd_n = 1'b0;
      @(negedge clk); pd_n = 1'b1;
      step(30);
      chk(osc_stop == 1'b0, "R2", "short pulse osc_stop", osc_stop, 0);
      chk(rise_cnt[6] > base[6], "R2", "out6 still switching", rise_cnt[6] - base[6], 1);

      // R4: power down, window for osc_stop
      step(3);
      exp_osc_q.push_back(1'b1);
      @(negedge clk); pd_n = 1'b0;
      k = 0;
      while (!osc_stop && k < 60) begin
         @(negedge clk); #1; k++;
      end
      chk(k >= 7, "R4", "osc_stop earliest edge", k, 7);
      chk(k <= 7 + MAXH, "R4", "osc_stop latest edge", k, 7 + MAXH);
      for (int i = 0; i < N; i++) base[i] = rise_cnt[i];
      step(40);
      for (int i = 0; i < N; i++)
         chk(rise_cnt[i] == base[i], "R4", $sformatf("no rise while down out%0d", i),
             rise_cnt[i] - base[i], 0);

      // R5: release latency of exactly 4 edges
      exp_osc_q.push_back(1'b0);
      @(negedge clk); pd_n = 1'b1;
      step(3);
      chk(osc_stop == 1'b1, "R5", "osc_stop after 3 edges", osc_stop, 1);
      step(1);
      chk(osc_stop == 1'b0, "R5", "osc_stop after 4 edges", osc_stop, 0);

      // R6: restart window per output
      for (int i = 0; i < N; i++) first[i] = -1;
      k = 0;
      while (k < RST + 4 * MAXH + 10) begin
         @(negedge clk); #1; k++;
         for (int i = 0; i < N; i++)
            if (first[i] < 0 && clk_out[i]) first[i] = k;
      end
      for (int i = 0; i < N; i++) begin
         chk(first[i] >= RST + 2, "R6", $sformatf("restart earliest out%0d", i),
             first[i], RST + 2);
         chk(first[i] > 0 && first[i] <= RST + 2 + 2 * (i + 1), "R6",
             $sformatf("restart latest out%0d", i), first[i], RST + 2 + 2 * (i + 1));
      end

      // R7: disable output 3
      @(negedge clk); en[3] = 1'b0;
      step(4 * 4);
      base[3] = rise_cnt[3]; base[5] = rise_cnt[5];
      step(40);
      chk(rise_cnt[3] == base[3], "R7", "out3 held low", rise_cnt[3] - base[3], 0);
      chk(clk_out[3] == 1'b0, "R7", "out3 level", clk_out[3], 0);
      chk(rise_cnt[5] > base[5], "R7", "out5 unaffected", rise_cnt[5] - base[5], 1);

      // R8: re-enable output 3
      @(negedge clk); en[3] = 1'b1;
      base[3] = rise_cnt[3];
      step(2 * 4 + 3);
      chk(rise_cnt[3] > base[3], "R8", "out3 resumes", rise_cnt[3] - base[3], 1);

      // R9: tristate control
      @(negedge clk); tristate = 1'b1;
      step(1);
      chk(clk_oe == '0, "R9", "oe after tristate 1", int'(clk_oe), 0);
      base[0] = rise_cnt[0];
      step(10);
      chk(rise_cnt[0] > base[0], "R9", "out0 switching while tristated",
          rise_cnt[0] - base[0], 1);
      @(negedge clk); tristate = 1'b0;
      step(1);
      chk(clk_oe == '1, "R9", "oe after tristate 0", int'(clk_oe), 127);

      step(20);
      chk(exp_osc_q.size() == 0, "R4", "pending osc_stop events", exp_osc_q.size(), 0);
      finish_sim();
   end
endmodule